// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block is a per-core timer peripheral on a small register bus. It keeps a 64-bit count of timer ticks since reset and a 64-bit software-written deadline. It drives a level interrupt line that goes to the machine timer-pending bit (bit 7 of the pending register) of the hart it serves. The line is high whenever the count has passed the deadline.

Software arms a timeout of N ticks in three steps: it reads the count, adds N, and writes the sum to the deadline. Both registers are reached as pairs of 32-bit words at fixed offsets, with the low word first. Byte strobes select the lanes a write touches. Reads are combinational from the address. A write to the deadline takes effect at the next clock edge, and the interrupt line follows the new value in that same cycle.

Top module: `mach_timer`

## Requirements
- R1: After reset the count reads 0, both deadline words read 0xFFFFFFFF, and the interrupt is low.
- R2: The count rises by exactly one on every clock edge where `tickEn` is high and no count write occurs. When `tickEn` is low it holds.
- R3: The count carries from the low word into the high word and wraps from all ones to zero (modulo 2^64).
- R4: The address map is fixed: deadline low word at 0x4000, deadline high word at 0x4004, count low word at 0xBFF8, count high word at 0xBFFC. `busRdata` shows the addressed word in the same cycle.
- R5: On a write, strobe bit k replaces byte k (bits 8k+7..8k) of the addressed word and leaves the other bytes unchanged.
- R6: A write to either count word overrides the increment on that edge. The written value is readable after the edge, and counting resumes from it on later ticks.
- R7: `timerIrq` is high exactly when the count is strictly greater than the deadline (unsigned). It changes only after an edge where a tick or a bus write occurred.
- R8: Rewriting the deadline to a value not less than the count drops `timerIrq` in the cycle right after the write edge.
- R9: Addresses outside the four words read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable for this cycle |
| busAddr | input | 16 | Byte address of the word accessed |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busStrb | input | 4 | Byte write strobes |
| busRdata | output | 32 | Read data for `busAddr` |
| timerIrq | output | 1 | Level timer interrupt |

## Verification
Read data depends only on the address and the current register contents, so a read is due in the same cycle the address is applied. A write or a tick becomes visible one edge later, in both read data and `timerIrq`, because the compare uses the registered values with no further stage. The bench drives inputs 2 ns after the rising edge and samples at the falling edge. Its per-cycle model applies each stimulus at the edge that consumes it, so every comparison looks at the cycle where that result is due.

// File: rtl/mach_timer_pkg.sv
package mach_timer_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TIME_LO,
    SEL_TIME_HI,
    SEL_CMP_LO,
    SEL_CMP_HI
  } rd_sel_e;

  typedef struct packed {
    logic    timeLoWr;
    logic    timeHiWr;
    logic    cmpLoWr;
    logic    cmpHiWr;
    rd_sel_e rdSel;
  } reg_ctl_t;

endpackage

// File: rtl/mach_timer_ctrl.sv
module mach_timer_ctrl
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CMP_OFF  = 16'h4000,
  parameter logic [ADDR_W-1:0] TIME_OFF = 16'hBFF8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output reg_ctl_t          ctl
);

  localparam logic [ADDR_W-1:0] CMP_HI  = CMP_OFF + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] TIME_HI = TIME_OFF + ADDR_W'(4);

  always_comb begin
    ctl = '0;
    ctl.rdSel = SEL_NONE;
    if (busAddr == TIME_OFF)     ctl.rdSel = SEL_TIME_LO;
    else if (busAddr == TIME_HI) ctl.rdSel = SEL_TIME_HI;
    else if (busAddr == CMP_OFF) ctl.rdSel = SEL_CMP_LO;
    else if (busAddr == CMP_HI)  ctl.rdSel = SEL_CMP_HI;
    ctl.timeLoWr = busWe && (ctl.rdSel == SEL_TIME_LO);
    ctl.timeHiWr = busWe && (ctl.rdSel == SEL_TIME_HI);
    ctl.cmpLoWr  = busWe && (ctl.rdSel == SEL_CMP_LO);
    ctl.cmpHiWr  = busWe && (ctl.rdSel == SEL_CMP_HI);
  end

endmodule

// File: rtl/mach_timer_dp.sv
module mach_timer_dp
  import mach_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [DATA_W/8-1:0]   busStrb,
  input  reg_ctl_t              ctl,
  output logic [2*DATA_W-1:0]   timeQ,
  output logic [2*DATA_W-1:0]   cmpQ,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  timerIrq
);

  localparam int CNT_W = 2 * DATA_W;
  localparam int NBYTE = DATA_W / 8;

  logic [DATA_W-1:0] laneMask;
  logic [CNT_W-1:0]  timeNext, cmpNext;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign laneMask[b*8 +: 8] = {8{busStrb[b]}};
  end

  function automatic logic [DATA_W-1:0] mergeWord(input logic [DATA_W-1:0] oldW,
                                                  input logic [DATA_W-1:0] newW,
                                                  input logic [DATA_W-1:0] mask);
    return (oldW & ~mask) | (newW & mask);
  endfunction

  always_comb begin
    timeNext = timeQ;
    if (ctl.timeLoWr || ctl.timeHiWr) begin
      if (ctl.timeLoWr)
        timeNext[DATA_W-1:0] = mergeWord(timeQ[DATA_W-1:0], busWdata, laneMask);
      if (ctl.timeHiWr)
        timeNext[CNT_W-1:DATA_W] = mergeWord(timeQ[CNT_W-1:DATA_W], busWdata, laneMask);
    end else if (tickEn) begin
      timeNext = timeQ + CNT_W'(1);
    end
  end

  always_comb begin
    cmpNext = cmpQ;
    if (ctl.cmpLoWr)
      cmpNext[DATA_W-1:0] = mergeWord(cmpQ[DATA_W-1:0], busWdata, laneMask);
    if (ctl.cmpHiWr)
      cmpNext[CNT_W-1:DATA_W] = mergeWord(cmpQ[CNT_W-1:DATA_W], busWdata, laneMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeQ <= '0;
      cmpQ  <= '1;
    end else begin
      timeQ <= timeNext;
      cmpQ  <= cmpNext;
    end
  end

  always_comb begin
    unique case (ctl.rdSel)
      SEL_TIME_LO: busRdata = timeQ[DATA_W-1:0];
      SEL_TIME_HI: busRdata = timeQ[CNT_W-1:DATA_W];
      SEL_CMP_LO:  busRdata = cmpQ[DATA_W-1:0];
      SEL_CMP_HI:  busRdata = cmpQ[CNT_W-1:DATA_W];
      default:     busRdata = '0;
    endcase
  end

  assign timerIrq = timeQ > cmpQ;

endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMP_OFF  = 16'h4000,
  parameter logic [ADDR_W-1:0] TIME_OFF = 16'hBFF8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W/8-1:0] busStrb,
  output logic [DATA_W-1:0]   busRdata,
  output logic                timerIrq
);

  localparam int CNT_W = 2 * DATA_W;

  reg_ctl_t         ctl;
  logic [CNT_W-1:0] timeVal;
  logic [CNT_W-1:0] cmpVal;

  mach_timer_ctrl #(
    .ADDR_W(ADDR_W), .CMP_OFF(CMP_OFF), .TIME_OFF(TIME_OFF)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .ctl(ctl)
  );

  mach_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .busWdata(busWdata), .busStrb(busStrb), .ctl(ctl),
    .timeQ(timeVal), .cmpQ(cmpVal),
    .busRdata(busRdata), .timerIrq(timerIrq)
  );

endmodule

// File: rtl/mach_timer_chk.sv
module mach_timer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMP_OFF  = 16'h4000,
  parameter logic [ADDR_W-1:0] TIME_OFF = 16'hBFF8
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W/8-1:0] busStrb,
  input logic [DATA_W-1:0]   busRdata,
  input logic                timerIrq,
  input logic [2*DATA_W-1:0] timeVal,
  input logic [2*DATA_W-1:0] cmpVal
);

  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] CMP_HI  = CMP_OFF + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] TIME_HI = TIME_OFF + ADDR_W'(4);

  logic timeWr, mappedAddr;
  assign timeWr     = busWe && (busAddr == TIME_OFF || busAddr == TIME_HI);
  assign mappedAddr = (busAddr == TIME_OFF) || (busAddr == TIME_HI) ||
                      (busAddr == CMP_OFF)  || (busAddr == CMP_HI);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !timeWr) |=> (timeVal == $past(timeVal) + CNT_W'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !timeWr) |=> $stable(timeVal));

  // R4
  time_lo_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == TIME_OFF) |-> (busRdata == timeVal[DATA_W-1:0]));

  // R6
  time_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == TIME_OFF && busStrb == '1) |=>
      (timeVal[DATA_W-1:0] == $past(busWdata)));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerIrq) |-> ($past(tickEn) || $past(busWe)));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !mappedAddr) |=> $stable(cmpVal));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mappedAddr |-> (busRdata == '0));

endmodule

bind mach_timer mach_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_OFF(CMP_OFF), .TIME_OFF(TIME_OFF)
) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busStrb(busStrb), .busRdata(busRdata),
  .timerIrq(timerIrq), .timeVal(timeVal), .cmpVal(cmpVal)
);

// File: tb/sim_mach_timer.sv
`timescale 1ns/1ps
module sim_mach_timer;

  localparam logic [15:0] A_CLO = 16'h4000;
  localparam logic [15:0] A_CHI = 16'h4004;
  localparam logic [15:0] A_TLO = 16'hBFF8;
  localparam logic [15:0] A_THI = 16'hBFFC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busStrb = '0;
  logic [31:0] busRdata;
  logic        timerIrq;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 0;

  logic [63:0] mTime = '0;
  logic [63:0] mCmp = '1;

  always #10 clk = ~clk;

  mach_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busStrb(busStrb), .busRdata(busRdata), .timerIrq(timerIrq)
  );

  function automatic logic [31:0] applyStrb(logic [31:0] oldW, logic [31:0] newW, logic [3:0] s);
    logic [31:0] r = oldW;
    for (int k = 0; k < 4; k++) if (s[k]) r[k*8 +: 8] = newW[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] modelRead(logic [15:0] a);
    case (a)
      A_TLO: return mTime[31:0];
      A_THI: return mTime[63:32];
      A_CLO: return mCmp[31:0];
      A_CHI: return mCmp[63:32];
      default: return 32'h0;
    endcase
  endfunction

  // Reference model: one update per rising edge.
  always @(posedge clk) begin
    if (!rstN) begin
      mTime = '0;
      mCmp  = '1;
    end else begin
      if (busWe && busAddr == A_TLO)      mTime[31:0]  = applyStrb(mTime[31:0], busWdata, busStrb);
      else if (busWe && busAddr == A_THI) mTime[63:32] = applyStrb(mTime[63:32], busWdata, busStrb);
      else if (tickEn)                    mTime = mTime + 64'd1;
      if (busWe && busAddr == A_CLO) mCmp[31:0]  = applyStrb(mCmp[31:0], busWdata, busStrb);
      if (busWe && busAddr == A_CHI) mCmp[63:32] = applyStrb(mCmp[63:32], busWdata, busStrb);
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R4 read data, R7 interrupt level).
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R4 read", {32'h0, busRdata}, {32'h0, modelRead(busAddr)});
      check("R7 irq", {63'h0, timerIrq}, {63'h0, (mTime > mCmp)});
    end
  end

  task automatic wr(logic [15:0] a, logic [31:0] d, logic [3:0] s);
    busAddr = a; busWdata = d; busStrb = s; busWe = 1'b1;
    @(posedge clk); #2;
    busWe = 1'b0;
  endtask

  task automatic rdChk(string req, logic [15:0] a, logic [31:0] exp);
    busAddr = a;
    @(negedge clk);
    check(req, {32'h0, busRdata}, {32'h0, exp});
    @(posedge clk); #2;
  endtask

  task automatic irqChk(string req, logic exp);
    @(negedge clk);
    check(req, {63'h0, timerIrq}, {63'h0, exp});
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    irqChk("R1 irq low", 1'b0);
    rdChk("R1 time lo", A_TLO, 32'h0);
    rdChk("R1 time hi", A_THI, 32'h0);
    rdChk("R1 cmp lo", A_CLO, 32'hFFFF_FFFF);
    rdChk("R1 cmp hi", A_CHI, 32'hFFFF_FFFF);

    // R2 counting and holding
    tickEn = 1'b1;
    repeat (7) @(posedge clk);
    #2 tickEn = 1'b0;
    rdChk("R2 seven ticks", A_TLO, 32'd7);
    rdChk("R2 holds", A_TLO, 32'd7);

    // R3 carry and wrap
    wr(A_TLO, 32'hFFFF_FFFE, 4'hF);
    wr(A_THI, 32'h0, 4'hF);
    tickEn = 1'b1;
    repeat (2) @(posedge clk);
    #2 tickEn = 1'b0;
    rdChk("R3 carry lo", A_TLO, 32'h0);
    rdChk("R3 carry hi", A_THI, 32'h1);
    wr(A_TLO, 32'hFFFF_FFFF, 4'hF);
    wr(A_THI, 32'hFFFF_FFFF, 4'hF);
    tickEn = 1'b1;
    @(posedge clk); #2 tickEn = 1'b0;
    rdChk("R3 wrap lo", A_TLO, 32'h0);
    rdChk("R3 wrap hi", A_THI, 32'h0);

    // R5 byte strobes
    wr(A_CLO, 32'h1122_3344, 4'b0101);
    rdChk("R5 strobes", A_CLO, 32'hFF22_FF44);

    // R9 unmapped
    wr(16'h1234, 32'hDEAD_BEEF, 4'hF);
    rdChk("R9 read zero", 16'h1234, 32'h0);
    rdChk("R9 cmp unchanged", A_CLO, 32'hFF22_FF44);

    // R6 write overrides tick
    tickEn = 1'b1;
    wr(A_TLO, 32'd5, 4'hF);
    rdChk("R6 loaded", A_TLO, 32'd5);
    rdChk("R6 resumes", A_TLO, 32'd6);
    tickEn = 1'b0;

    // R7 compare
    wr(A_THI, 32'h0, 4'hF);
    wr(A_TLO, 32'd100, 4'hF);
    wr(A_CHI, 32'h0, 4'hF);
    wr(A_CLO, 32'd100, 4'hF);
    irqChk("R7 equal no irq", 1'b0);
    tickEn = 1'b1;
    @(posedge clk); #2 tickEn = 1'b0;
    irqChk("R7 greater irq", 1'b1);
    // R8 rearm
    wr(A_CLO, 32'd200, 4'hF);
    irqChk("R8 drops", 1'b0);
    wr(A_CLO, 32'd101, 4'hF);
    irqChk("R8 equal stays low", 1'b0);

    // long run with random-like activity compared per cycle
    for (int i = 0; i < 200; i++) begin
      tickEn = i[0] ^ i[3];
      if (i % 37 == 0) wr(A_CLO, mTime[31:0] + 32'd9, 4'hF);
      else begin @(posedge clk); #2; end
    end
    tickEn = 1'b0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule